// File: doc/BRIEF.md
# Shared Timebase Counter with Split-Byte Snapshot Reads

This block is the common time reference for a group of capture/compare channels. It holds a 16-bit up-counter. The counter sits idle until its run control is set. From then on it advances by one on every cycle in which the selected clock-enable tick is high. The live count goes straight to every channel, so all channels see the same time. When the count passes its top value and returns to zero, the block raises a single-cycle overflow event. This event drives one interrupt output and one line per channel.

Software reads the count over a byte-wide port, one byte per read strobe, and reads the low byte first. A low-byte read does two things at the same clock edge: it returns the live low byte and it saves the live high byte in a hidden register. A later high-byte read returns that saved byte, not the live one. The two reads therefore make up one coherent 16-bit value, however many ticks pass between them.

The read port is a plain strobe with an address select. Every strobe is accepted, so the port has no back-pressure. The addressed byte appears on the data output one cycle after the strobe, together with a one-cycle valid flag. Reset is synchronous and active high.

Top module: `tbase_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count, the saved high byte, `rd_data`, `rd_vld` and every overflow output become zero at that edge.
- R2: At any edge where `run_en` is low, or `tick` is low, the count keeps its value.
- R3: At an edge where both `run_en` and `tick` are high, the count becomes (count + 1) modulo 65536.
- R4: `count_o` and each 16-bit slice of `chan_time_o` (channel k occupies bits 16k+15 down to 16k) equal the live count in every cycle.
- R5: A strobe with `rd_hi` = 0 (the low-byte select) sets `rd_data` at the next edge to bits 7:0 of the count as it stood before that edge. At the same edge the saved high byte becomes bits 15:8 of that same count.
- R6: A strobe with `rd_hi` = 1 (the high-byte select) sets `rd_data` at the next edge to the saved high byte, whatever the live high byte is. A high-byte strobe leaves the saved byte unchanged.
- R7: A high-byte strobe with no low-byte strobe since reset returns zero. Repeated high-byte strobes return the same saved byte.
- R8: An edge that advances the count from 0xFFFF to 0x0000 drives `ovf_irq` and every bit of `chan_ovf_o` high for exactly the following cycle. These outputs are low in every other cycle.
- R9: `rd_vld` is high in exactly the cycle after each edge that samples `rd_stb` high. `rd_data` keeps its value when no strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run control; the counter advances only while this is high |
| tick | input | 1 | Selected clock-enable tick |
| rd_stb | input | 1 | Byte read strobe |
| rd_hi | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Byte returned by the last read |
| rd_vld | output | 1 | One-cycle flag marking a new `rd_data` |
| count_o | output | 16 | Live count |
| chan_time_o | output | 64 | Live count copied once for each of the four channels |
| ovf_irq | output | 1 | Overflow event to the interrupt controller |
| chan_ovf_o | output | 4 | Overflow event, one line per channel |

## Verification
Two functions can land on the same edge: a low-byte read, and the increment that wraps the count from 0xFFFF to zero. The bench runs the counter up to 0xFFFF with the tick held high. It then issues a low-byte strobe in exactly the cycle in which the wrapping tick is applied. The expected result is 0xFF for the low byte, and 0xFF for the later high-byte read, even though the live count by then reads 0x0000. The overflow pulse must show up in the same cycle as the low-byte data and last for that one cycle only.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int TB_CNT_W  = 16;
  localparam int TB_BYTE_W = 8;
  localparam int TB_N_CH   = 4;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/tbase_count.sv
module tbase_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic adv;
  assign adv = run_en & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= adv && (cnt_o == TOP);
      if (adv) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2: no advance without run and tick
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(run_en && tick) |=> $stable(cnt_o));

  // R3: one step per qualified tick, modulo wrap
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run_en && tick) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R8: overflow only while count reads zero
  p_ovf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (cnt_o == '0));

  // R8: overflow lasts a single cycle
  p_ovf_single_r8: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/tbase_rdport.sv
module tbase_rdport
  import tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              rd_hi,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int HI_W = CNT_W - BYTE_W;

  byte_sel_e         sel;
  logic [HI_W-1:0]   hi_save;

  assign sel = byte_sel_e'(rd_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_save <= '0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) begin
        if (sel == SEL_LO) begin
          rd_data <= cnt_i[BYTE_W-1:0];
          hi_save <= cnt_i[CNT_W-1:BYTE_W];
        end else begin
          rd_data <= BYTE_W'(hi_save);
        end
      end
    end
  end

  // R5: low read returns low byte sampled at the strobe edge
  p_lo_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_hi) |=> (rd_data == $past(cnt_i[BYTE_W-1:0])));

  // R6: saved byte only moves on a low-byte read
  p_save_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && !rd_hi) |=> $stable(hi_save));

  // R6: high read returns saved byte
  p_hi_byte_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_hi) |=> (rd_data == BYTE_W'($past(hi_save))));

  // R9: valid follows strobe; data held otherwise
  p_vld_r9: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_vld);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> (!rd_vld && $stable(rd_data)));
endmodule

// File: rtl/tbase_fanout.sv
module tbase_fanout #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  wrap_i,
  output logic [N_CH*CNT_W-1:0] chan_time_o,
  output logic [N_CH-1:0]       chan_ovf_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign chan_time_o[k*CNT_W +: CNT_W] = cnt_i;
    assign chan_ovf_o[k]                 = wrap_i;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W  = TB_CNT_W,
  parameter int BYTE_W = TB_BYTE_W,
  parameter int N_CH   = TB_N_CH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic                  tick,
  input  logic                  rd_stb,
  input  logic                  rd_hi,
  output logic [BYTE_W-1:0]     rd_data,
  output logic                  rd_vld,
  output logic [CNT_W-1:0]      count_o,
  output logic [N_CH*CNT_W-1:0] chan_time_o,
  output logic                  ovf_irq,
  output logic [N_CH-1:0]       chan_ovf_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  tbase_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .tick   (tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  tbase_rdport #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .rd_hi   (rd_hi),
    .cnt_i   (cnt),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  tbase_fanout #(.CNT_W(CNT_W), .N_CH(N_CH)) u_fan (
    .cnt_i       (cnt),
    .wrap_i      (wrap),
    .chan_time_o (chan_time_o),
    .chan_ovf_o  (chan_ovf_o)
  );

  assign count_o = cnt;
  assign ovf_irq = wrap;

  // R1: reset clears visible state
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && rd_data == '0 && !rd_vld && !ovf_irq));

  // R8: interrupt and channel lines agree
  p_ovf_lines_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (chan_ovf_o == {N_CH{1'b1}}));
endmodule

// File: tb/sim_tbase_counter.sv
module sim_tbase_counter;
  localparam int CW = 16;
  localparam int BW = 8;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, run_en = 1'b0, tick = 1'b0, rd_stb = 1'b0, rd_hi = 1'b0;
  logic [BW-1:0]    rd_data;
  logic             rd_vld;
  logic [CW-1:0]    count_o;
  logic [NC*CW-1:0] chan_time_o;
  logic             ovf_irq;
  logic [NC-1:0]    chan_ovf_o;

  tbase_counter u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
    .rd_stb(rd_stb), .rd_hi(rd_hi), .rd_data(rd_data), .rd_vld(rd_vld),
    .count_o(count_o), .chan_time_o(chan_time_o),
    .ovf_irq(ovf_irq), .chan_ovf_o(chan_ovf_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt = 0, m_save = 0, m_rd = 0;
  bit m_vld = 0, m_ovf = 0, m_lastsel = 0;
  bit done = 0;
  int lfsr = 32'h1ACE;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(count_o == m_cnt[CW-1:0], "R3", "count_o", count_o, m_cnt);
    for (int k = 0; k < NC; k++)
      chk(chan_time_o[k*CW +: CW] == m_cnt[CW-1:0], "R4", "chan_time",
          chan_time_o[k*CW +: CW], m_cnt);
    chk(ovf_irq == m_ovf, "R8", "ovf_irq", ovf_irq, m_ovf);
    chk(chan_ovf_o == {NC{m_ovf}}, "R8", "chan_ovf_o", chan_ovf_o, {NC{m_ovf}});
    chk(rd_vld == m_vld, "R9", "rd_vld", rd_vld, m_vld);
    chk(rd_data == m_rd[BW-1:0], m_lastsel ? "R6" : "R5", "rd_data", rd_data, m_rd);
  endtask

  task automatic step(bit s, bit h, bit r, bit t);
    rd_stb = s; rd_hi = h; run_en = r; tick = t;
    @(posedge clk);
    cyc++;
    if (rst) begin
      m_cnt = 0; m_save = 0; m_rd = 0; m_vld = 0; m_ovf = 0; m_lastsel = 0;
    end else begin
      m_vld = s;
      if (s) begin
        m_lastsel = h;
        if (!h) begin
          m_rd   = m_cnt % 256;
          m_save = m_cnt / 256;
        end else m_rd = m_save;
      end
      m_ovf = r && t && (m_cnt == 65535);
      if (r && t) m_cnt = (m_cnt + 1) % 65536;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 190000) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  initial begin
    int hold;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    rst = 1'b0;
    // R1: reset state
    chk(count_o == 0 && rd_data == 0 && !rd_vld && !ovf_irq, "R1", "reset outputs",
        {count_o, rd_data}, 0);

    // R7: high read before any low read
    step(1, 1, 0, 0);
    chk(rd_data == 0, "R7", "hi read after reset", rd_data, 0);

    // R2: tick without run
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    chk(count_o == 0, "R2", "idle while run low", count_o, 0);

    // R3/R5/R6/R9: pseudo-random ticks and reads
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) ? 32'h04C11DB7 : 0);
      step(lfsr[3], lfsr[5], 1'b1, lfsr[0] | lfsr[7]);
    end

    // R2: run dropped with tick high
    hold = count_o;
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1);
    chk(count_o == hold[CW-1:0], "R2", "hold on run low", count_o, hold);

    // R8: run to top of range
    while (m_cnt != 65535) step(0, 0, 1, 1);
    // low read on the wrapping edge
    step(1, 0, 1, 1);
    chk(rd_data == 8'hFF, "R5", "low byte at wrap", rd_data, 8'hFF);
    chk(ovf_irq && count_o == 0, "R8", "ovf at wrap", {ovf_irq, count_o}, 32'h10000);
    step(0, 0, 1, 1);
    chk(!ovf_irq, "R8", "ovf single cycle", ovf_irq, 0);
    step(1, 1, 1, 0);
    chk(rd_data == 8'hFF && count_o[15:8] == 0, "R6", "saved high byte",
        {rd_data, count_o[15:8]}, 16'hFF00);
    step(1, 1, 0, 0);
    chk(rd_data == 8'hFF, "R7", "repeat high read", rd_data, 8'hFF);

    // R1: synchronous reset clears saved byte
    rst = 1'b1;
    step(0, 0, 1, 1);
    rst = 1'b0;
    step(1, 1, 0, 0);
    chk(rd_data == 0, "R1", "saved byte cleared", rd_data, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule